// File: doc/BRIEF.md
# System Bus Ownership Arbiter with External Hand-Off

This block decides which of four masters drives a shared system bus: the processor, an on-chip DMA engine, a DRAM refresh sequencer, or a device outside the chip. The processor holds the bus by default. The other masters take it only when the current owner reaches a clean stopping point. For the processor that point is the end of one of its bus cycles. For the DMA engine it is the end of a whole byte or word transfer, never the gap between the read half and the write half. For the refresh sequencer it is the end of its refresh cycle.

The external device asks for the bus by pulling an active-low request line. The request counts only while a release-enable input is set. Once the external device wins, the block stops driving the address lines and strobes, forces every chip select inactive and pulls an active-low acknowledge. The device keeps the bus until its request has been seen high on a parameterised number of back-to-back clock edges, which is two by default. The block drives no bus cycles itself; it only produces the grants and the pin controls.

Top module: `bus_owner_arb`

## Requirements
- R1: While reset is asserted and right after it is released, the grant vector is 4'b0001 (processor), `ext_ack_n` is 1, `bus_drv_en` is 1 and `cs_n_out` equals `cs_n_in`.
- R2: `gnt` is one-hot in every cycle, with bit 0 for the processor, bit 1 for DMA, bit 2 for refresh and bit 3 for the external master.
- R3: Ownership moves only at a boundary of the current owner: `cpu_cyc_end` for the processor, `dma_xfer_done` (end of a complete read-then-write transfer) for DMA, `rfsh_done` for refresh. Requests that arrive at any other time wait.
- R4: At a boundary the next owner is picked in this order: external master (release enabled and request sampled low), then refresh, then DMA, then the processor when nothing else is pending.
- R5: The refresh sequencer loses the bus on the edge where `rfsh_done` is 1, and it is not granted again on that same edge.
- R6: While `ext_rel_en` is 0, a low `ext_req_n` is ignored: bit 3 of `gnt` stays 0 and `ext_ack_n` stays 1.
- R7: `ext_req_n` is judged only by its value at the rising clock edge. A low pulse that has gone high again before the edge has no effect.
- R8: Once the external master holds the bus, it keeps it while `ext_req_n` is sampled low, even if `ext_rel_en` is cleared.
- R9: The external master gives up the bus only after `ext_req_n` has been sampled high on REL_SAMPLES consecutive edges (two by default). A low sample in between restarts the count. On release, the bus goes to the highest pending internal requester.
- R10: While the external master owns the bus, `ext_ack_n` is 0, `bus_drv_en` is 0 and every bit of `cs_n_out` is 1. At all other times `ext_ack_n` is 1, `bus_drv_en` is 1 and `cs_n_out` equals `cs_n_in`.
- R11: At a transfer boundary, DMA keeps the bus if it is still requesting and neither the external master nor refresh is asking for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rel_en | input | 1 | Enable for handing the bus to the external master |
| ext_req_n | input | 1 | Active-low bus request from the external master |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_xfer_done | input | 1 | Pulse at the end of the write half of a DMA transfer |
| cpu_cyc_end | input | 1 | Pulse at the end of a processor bus cycle (held high while idle) |
| rfsh_req | input | 1 | Refresh sequencer wants the bus |
| rfsh_done | input | 1 | Pulse at the end of a refresh cycle |
| cs_n_in | input | NUM_CS | Chip selects from the address decoder |
| gnt | output | 4 | One-hot ownership vector |
| ext_ack_n | output | 1 | Active-low acknowledge to the external master |
| bus_drv_en | output | 1 | Output enable for the address bus and the read/write/address strobes |
| cs_n_out | output | NUM_CS | Chip selects to the pins, forced high during external ownership |

## Verification
The bench builds the block with NUM_CS = 8, REL_SAMPLES = 2 and EXTRA_SYNC = 0. With no extra synchroniser stage, each value placed on the request line settles ownership on the very next edge. That lets the table place a single high sample, a reset of the count by a low sample, and a two-sample release on adjacent rows, and lets a directed test show that a pulse gone before the edge is not seen. Eight chip-select lines with alternating bit patterns show both the pass-through and the forced-high state on every bit.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   localparam int unsigned NUM_MASTERS = 4;

   typedef enum logic [1:0] {
      OWN_CPU  = 2'd0,
      OWN_DMA  = 2'd1,
      OWN_RFSH = 2'd2,
      OWN_EXT  = 2'd3
   } owner_e;
endpackage

// File: rtl/bus_arb_req_sampler.sv
// Samples the external request line and counts back-to-back high samples.
module bus_arb_req_sampler #(
   parameter int unsigned REL_SAMPLES = 2,
   parameter int unsigned EXTRA_SYNC  = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_pin,
   output logic req_lo,     // request is low at this edge
   output logic rel_ok      // this edge completes the high-sample run
);
   localparam int unsigned CW = $clog2(REL_SAMPLES + 1);

   logic          req_n_s;
   logic [CW-1:0] hi_cnt;

   generate
      if (EXTRA_SYNC == 0) begin : g_direct
         assign req_n_s = req_n_pin;
      end else begin : g_sync
         logic [EXTRA_SYNC-1:0] stg;
         for (genvar i = 0; i < EXTRA_SYNC; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[0] <= 1'b1;
                  else        stg[0] <= req_n_pin;
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n)
                  if (!rst_n) stg[i] <= 1'b1;
                  else        stg[i] <= stg[i-1];
            end
         end
         assign req_n_s = stg[EXTRA_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hi_cnt <= '0;
      else if (!req_n_s)                 hi_cnt <= '0;
      else if (hi_cnt != CW'(REL_SAMPLES)) hi_cnt <= hi_cnt + 1'b1;
   end

   assign req_lo = ~req_n_s;
   assign rel_ok = req_n_s && (hi_cnt >= CW'(REL_SAMPLES - 1));
endmodule

// File: rtl/bus_arb_owner_fsm.sv
// Holds the current owner and moves it only at that owner's boundary.
module bus_arb_owner_fsm
   import bus_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ext_want,
   input  logic   rel_ok,
   input  logic   dma_req,
   input  logic   dma_xfer_done,
   input  logic   cpu_cyc_end,
   input  logic   rfsh_req,
   input  logic   rfsh_done,
   output owner_e owner
);
   owner_e nxt;

   function automatic owner_e pick(input logic e, input logic r, input logic d);
      if (e)      return OWN_EXT;
      else if (r) return OWN_RFSH;
      else if (d) return OWN_DMA;
      else        return OWN_CPU;
   endfunction

   always_comb begin
      nxt = owner;
      unique case (owner)
         OWN_CPU:  if (cpu_cyc_end)   nxt = pick(ext_want, rfsh_req, dma_req);
         OWN_DMA:  if (dma_xfer_done) nxt = pick(ext_want, rfsh_req, dma_req);
         OWN_RFSH: if (rfsh_done)     nxt = pick(ext_want, 1'b0, dma_req);
         OWN_EXT:  if (rel_ok)        nxt = pick(1'b0, rfsh_req, dma_req);
         default:                     nxt = OWN_CPU;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) owner <= OWN_CPU;
      else        owner <= nxt;
endmodule

// File: rtl/bus_arb_pin_ctrl.sv
// Decodes the owner into grants and the pin-level controls.
module bus_arb_pin_ctrl
   import bus_arb_pkg::*;
#(
   parameter int unsigned NUM_CS = 8
) (
   input  owner_e                  owner,
   input  logic [NUM_CS-1:0]       cs_n_in,
   output logic [NUM_MASTERS-1:0]  gnt,
   output logic                    ext_ack_n,
   output logic                    bus_drv_en,
   output logic [NUM_CS-1:0]       cs_n_out
);
   logic ext_own;

   assign ext_own = (owner == OWN_EXT);

   generate
      for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_gnt
         assign gnt[m] = (owner == owner_e'(2'(m)));
      end
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign cs_n_out[c] = cs_n_in[c] | ext_own;
      end
   endgenerate

   assign ext_ack_n  = ~ext_own;
   assign bus_drv_en = ~ext_own;
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
   import bus_arb_pkg::*;
#(
   parameter int unsigned NUM_CS      = 8,
   parameter int unsigned REL_SAMPLES = 2,
   parameter int unsigned EXTRA_SYNC  = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ext_rel_en,
   input  logic                   ext_req_n,
   input  logic                   dma_req,
   input  logic                   dma_xfer_done,
   input  logic                   cpu_cyc_end,
   input  logic                   rfsh_req,
   input  logic                   rfsh_done,
   input  logic [NUM_CS-1:0]      cs_n_in,
   output logic [NUM_MASTERS-1:0] gnt,
   output logic                   ext_ack_n,
   output logic                   bus_drv_en,
   output logic [NUM_CS-1:0]      cs_n_out
);
   generate
      if (REL_SAMPLES < 1) begin : g_bad_rel
         $error("REL_SAMPLES must be at least 1");
      end
      if (NUM_CS < 1) begin : g_bad_cs
         $error("NUM_CS must be at least 1");
      end
      if (EXTRA_SYNC > 4) begin : g_bad_sync
         $error("EXTRA_SYNC above 4 is not supported");
      end
   endgenerate

   logic   req_lo;
   logic   rel_ok;
   owner_e owner;

   bus_arb_req_sampler #(
      .REL_SAMPLES(REL_SAMPLES),
      .EXTRA_SYNC (EXTRA_SYNC)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_n_pin(ext_req_n),
      .req_lo   (req_lo),
      .rel_ok   (rel_ok)
   );

   bus_arb_owner_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_want     (ext_rel_en & req_lo),
      .rel_ok       (rel_ok),
      .dma_req      (dma_req),
      .dma_xfer_done(dma_xfer_done),
      .cpu_cyc_end  (cpu_cyc_end),
      .rfsh_req     (rfsh_req),
      .rfsh_done    (rfsh_done),
      .owner        (owner)
   );

   bus_arb_pin_ctrl #(.NUM_CS(NUM_CS)) u_pins (
      .owner     (owner),
      .cs_n_in   (cs_n_in),
      .gnt       (gnt),
      .ext_ack_n (ext_ack_n),
      .bus_drv_en(bus_drv_en),
      .cs_n_out  (cs_n_out)
   );
endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk #(
   parameter int unsigned NUM_CS      = 8,
   parameter int unsigned REL_SAMPLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_rel_en,
   input logic              ext_req_n,
   input logic              dma_req,
   input logic              dma_xfer_done,
   input logic              cpu_cyc_end,
   input logic              rfsh_req,
   input logic              rfsh_done,
   input logic [NUM_CS-1:0] cs_n_in,
   input logic [3:0]        gnt,
   input logic              ext_ack_n,
   input logic              bus_drv_en,
   input logic [NUM_CS-1:0] cs_n_out
);
   logic [15:0] hi_run;
   logic        ext_ask;

   assign ext_ask = ext_rel_en && !ext_req_n;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             hi_run <= '0;
      else if (!ext_req_n)    hi_run <= '0;
      else if (hi_run != '1)  hi_run <= hi_run + 1'b1;

   AST_RESET_CPU: assert property (@(posedge clk) !rst_n |-> gnt == 4'b0001); // R1
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $countones(gnt) == 1); // R2
   AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gnt[0] && !cpu_cyc_end |=> gnt[0]); // R3
   AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gnt[1] && !dma_xfer_done |=> gnt[1]); // R3
   AST_RFSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gnt[2] && !rfsh_done |=> gnt[2]); // R3
   AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) gnt[0] && cpu_cyc_end && ext_ask |=> gnt[3]); // R4
   AST_RFSH_OVER_DMA: assert property (@(posedge clk) disable iff (!rst_n) gnt[0] && cpu_cyc_end && rfsh_req && !ext_ask |=> gnt[2]); // R4
   AST_RFSH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n) gnt[2] && rfsh_done |=> !gnt[2]); // R5
   AST_EXT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !gnt[3] && !ext_rel_en |=> !gnt[3]); // R6
   AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n) gnt[3] && !ext_req_n |=> gnt[3]); // R8
   AST_REL_RUN: assert property (@(posedge clk) disable iff (!rst_n) $rose(ext_ack_n) |-> hi_run >= 16'(REL_SAMPLES)); // R9
   AST_PINS_EXT: assert property (@(posedge clk) disable iff (!rst_n) gnt[3] |-> !ext_ack_n && !bus_drv_en && (&cs_n_out)); // R10
   AST_PINS_OWN: assert property (@(posedge clk) disable iff (!rst_n) !gnt[3] |-> ext_ack_n && bus_drv_en && cs_n_out == cs_n_in); // R10
   AST_DMA_STAYS: assert property (@(posedge clk) disable iff (!rst_n) gnt[1] && dma_xfer_done && dma_req && !rfsh_req && !ext_ask |=> gnt[1]); // R11
endmodule

bind bus_owner_arb bus_owner_arb_chk #(.NUM_CS(NUM_CS), .REL_SAMPLES(REL_SAMPLES)) u_chk (.*);

// File: tb/bus_owner_arb_tb.sv
module bus_owner_arb_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 23;

   // {ext_rel_en, ext_req_n, dma_req, dma_xfer_done, cpu_cyc_end, rfsh_req, rfsh_done, expected gnt}
   localparam logic [10:0] VEC [NVEC] = '{
      {7'b0100000, 4'b0001},  //  0 R3 idle, no boundary
      {7'b0110000, 4'b0001},  //  1 R3 DMA waits for processor cycle end
      {7'b0110100, 4'b0010},  //  2 R4 DMA granted
      {7'b0110010, 4'b0010},  //  3 R3 refresh waits mid-transfer
      {7'b0111010, 4'b0100},  //  4 R4 refresh beats DMA
      {7'b0110010, 4'b0100},  //  5 R3 refresh holds
      {7'b0110011, 4'b0010},  //  6 R5 refresh done, DMA next
      {7'b0111000, 4'b0010},  //  7 R11 DMA keeps the bus
      {7'b0101000, 4'b0001},  //  8 R4 default to processor
      {7'b0000100, 4'b0001},  //  9 R6 release disabled, request ignored
      {7'b1010010, 4'b0001},  // 10 R3 no processor boundary yet
      {7'b1010110, 4'b1000},  // 11 R4 external beats all
      {7'b0000000, 4'b1000},  // 12 R8 enable cleared, still held
      {7'b0110000, 4'b1000},  // 13 R9 one high sample only
      {7'b0010000, 4'b1000},  // 14 R9 low sample restarts count
      {7'b0110010, 4'b1000},  // 15 R9 first high sample
      {7'b0110010, 4'b0100},  // 16 R9 second high sample, refresh next
      {7'b0110011, 4'b0010},  // 17 R5 refresh done
      {7'b1010000, 4'b0010},  // 18 R3 external waits for transfer end
      {7'b1011000, 4'b1000},  // 19 R4 external at transfer boundary
      {7'b1100000, 4'b1000},  // 20 R9 first high sample
      {7'b1100000, 4'b0001},  // 21 R9 released to processor
      {7'b1100100, 4'b0001}   // 22 R2 stays with processor
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ext_rel_en, ext_req_n, dma_req, dma_xfer_done;
   logic       cpu_cyc_end, rfsh_req, rfsh_done;
   logic [7:0] cs_n_in;
   logic [3:0] gnt;
   logic       ext_ack_n, bus_drv_en;
   logic [7:0] cs_n_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bus_owner_arb u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rel_en(ext_rel_en), .ext_req_n(ext_req_n),
      .dma_req(dma_req), .dma_xfer_done(dma_xfer_done), .cpu_cyc_end(cpu_cyc_end),
      .rfsh_req(rfsh_req), .rfsh_done(rfsh_done), .cs_n_in(cs_n_in), .gnt(gnt),
      .ext_ack_n(ext_ack_n), .bus_drv_en(bus_drv_en), .cs_n_out(cs_n_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pins_idle(input string tag, input logic [7:0] cs);
      chk({tag, " ack"}, 32'(ext_ack_n), 32'd1);
      chk({tag, " drv"}, 32'(bus_drv_en), 32'd1);
      chk({tag, " cs"}, 32'(cs_n_out), 32'(cs));
   endtask

   task automatic settle();
      @(posedge clk);
      #(CLK_PERIOD / 4);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      {ext_rel_en, dma_req, dma_xfer_done, cpu_cyc_end, rfsh_req, rfsh_done} = '0;
      ext_req_n = 1'b1;
      cs_n_in   = 8'hA5;
      repeat (2) @(posedge clk);
      #(CLK_PERIOD / 4);
      chk("R1 gnt in reset", 32'(gnt), 32'h1);
      pins_idle("R1 in reset", 8'hA5);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R1 gnt after reset", 32'(gnt), 32'h1);
      pins_idle("R1 after reset", 8'hA5);

      cs_n_in = 8'h5A;
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {ext_rel_en, ext_req_n, dma_req, dma_xfer_done, cpu_cyc_end, rfsh_req, rfsh_done} = VEC[i][10:4];
         settle();
         chk($sformatf("R2 table row %0d gnt", i), 32'(gnt), 32'(VEC[i][3:0]));
         chk($sformatf("R10 table row %0d ack", i), 32'(ext_ack_n), 32'(!VEC[i][3]));
         chk($sformatf("R10 table row %0d drv", i), 32'(bus_drv_en), 32'(!VEC[i][3]));
         chk($sformatf("R10 table row %0d cs", i), 32'(cs_n_out), VEC[i][3] ? 32'hFF : 32'h5A);
      end

      // R7: low pulse that is gone before the edge is not seen
      @(negedge clk);
      {ext_rel_en, dma_req, dma_xfer_done, rfsh_req, rfsh_done} = 5'b10000;
      cpu_cyc_end = 1'b1;
      ext_req_n   = 1'b0;
      #(CLK_PERIOD / 4);
      ext_req_n   = 1'b1;
      settle();
      chk("R7 pulse between edges", 32'(gnt), 32'h1);
      chk("R7 ack after pulse", 32'(ext_ack_n), 32'd1);

      // R7 / R10: request held across the edge is taken, pins released
      @(negedge clk);
      ext_req_n = 1'b0;
      cs_n_in   = 8'h00;
      settle();
      chk("R7 sampled low", 32'(gnt), 32'h8);
      chk("R10 ack low", 32'(ext_ack_n), 32'd0);
      chk("R10 drive off", 32'(bus_drv_en), 32'd0);
      chk("R10 chip selects high", 32'(cs_n_out), 32'hFF);

      // R1: reset during external ownership returns the bus to the processor
      @(negedge clk);
      rst_n   = 1'b0;
      cs_n_in = 8'h3C;
      #(CLK_PERIOD / 4);
      chk("R1 reset mid-release", 32'(gnt), 32'h1);
      pins_idle("R1 reset mid-release", 8'h3C);
      @(negedge clk);
      ext_req_n = 1'b1;
      rst_n     = 1'b1;
      settle();
      chk("R1 after second reset", 32'(gnt), 32'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule